// File: doc/BRIEF.md
# Bidirectional Splittable Row Scan Register

This block is the row scan shifter of a dot-matrix LCD driver working as a row (common) driver. A chain of 240 stages advances once per latch pulse, a slow strobe well below the column data clock. Each stage holds the select state of one row. The chain runs either as a single 240-row chain or as two independent 120-row halves. The shift direction is chosen by a pin. The scan token therefore walks rows 1 to 240, rows 240 to 1, or both halves at once.

Two edge pins carry the serial scan data between cascaded drivers. The pin that receives and the pin that sends swap roles with the direction. When the chain is split, a separate data input feeds the second half. The stage vector is combined with the frame polarity and a display-blank input to give a per-row select flag and a per-row level phase. These go to the output voltage stages, which are outside this block.

Top module: `rowscan_shifter`

## Requirements
- R1: A synchronous active-low reset clears all stages to non-select (0) and sets the topology to single chain, forward direction.
- R2: Stages change only in a clock cycle where `shift_en` is 1; in any other cycle every stage holds its value.
- R3: Single forward (`split_sel`=0, `dir_rev`=0): on a shift, `a_in` enters row 1 and row k takes the value of row k-1. `b_out` carries row 240.
- R4: Single reverse (`split_sel`=0, `dir_rev`=1): on a shift, `b_in` enters row 240 and row k takes the value of row k+1. `a_out` carries row 1.
- R5: Dual forward (`split_sel`=1, `dir_rev`=0): `a_in` enters row 1 and shifts up to row 120. `dual_in` enters row 121 and shifts up to row 240. Row 120 never passes to row 121. `b_out` carries row 120.
- R6: Dual reverse (`split_sel`=1, `dir_rev`=1): `b_in` enters row 240 and shifts down to row 121. `dual_in` enters row 120 and shifts down to row 1. `a_out` carries row 121.
- R7: Exactly one edge pin drives at any time. In forward direction `b_oe`=1 and `a_oe`=0, with `a_out`=0. In reverse direction `a_oe`=1 and `b_oe`=0, with `b_out`=0.
- R8: A shift uses the `split_sel` and `dir_rev` values present at that shift. Pin roles and the serial-out source follow them from that shift onward. A change of these pins without a shift changes no output.
- R9: With `disp_off`=0, `row_sel` equals the stage vector. `row_hi` equals `fr` for a selected row and the inverse of `fr` for an unselected row.
- R10: With `disp_off`=1, `row_sel` and `row_hi` are all 0, whatever the stage contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Latch pulse strobe, one cycle per row shift |
| split_sel | input | 1 | 1 = two 120-row halves, 0 = one 240-row chain |
| dir_rev | input | 1 | 1 = shift toward row 1, 0 = toward row 240 |
| fr | input | 1 | Frame polarity |
| disp_off | input | 1 | Blank all rows to the low deselect level |
| a_in | input | 1 | Row-1 edge pin, input side |
| a_out | output | 1 | Row-1 edge pin, output side |
| a_oe | output | 1 | Row-1 edge pin drive enable |
| b_in | input | 1 | Row-240 edge pin, input side |
| b_out | output | 1 | Row-240 edge pin, output side |
| b_oe | output | 1 | Row-240 edge pin drive enable |
| dual_in | input | 1 | Serial input of the second half when split |
| row_sel | output | 240 | Per-row select flag |
| row_hi | output | 240 | Per-row level phase |

## Verification
A corrupted stage shows up on `row_sel` in the same cycle, because the output path has no register. A wrong next-state link (a missing seam at row 120/121, or a wrong neighbour) shows up after the next shift. The error also reaches the serial-out pin once the token has walked to the end of the chain. A stale or wrong captured topology shows up as swapped drive enables or the wrong serial-out row right after the shift that should have loaded it. Random shifts under all four topologies are compared row by row against a bench model every cycle, so a fault is reported within one clock of its first visible effect.

// File: rtl/rowscan_pkg.sv
// Shared types for the row scan register.
// Assumes: the topology is captured as two independent flags.
package rowscan_pkg;

    // Chain topology captured at each shift
    typedef struct packed {
        logic split;   // 1 = two halves
        logic rev;     // 1 = shift toward row 1
    } topo_t;

    localparam topo_t TOPO_RESET = '{split: 1'b0, rev: 1'b0};

endpackage

// File: rtl/rowscan_chain.sv
// Stage register with per-stage neighbour selection.
// Assumes: STAGES is even. Stage i holds row i+1.
// The topology pins apply directly on the shift cycle.
module rowscan_chain #(
    parameter int STAGES = 240,
    localparam int HALF = STAGES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              split_nx,
    input  logic              rev_nx,
    input  logic              head_in,
    input  logic              dual_in,
    output logic [STAGES-1:0] stage_q
);

    logic [STAGES-1:0] stage_nx;

    // Per-stage next value: pick the upstream neighbour for the topology
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic fwd_src;
        logic rev_src;

        if (i == 0) begin : g_fwd_head
            assign fwd_src = head_in;
        end else if (i == HALF) begin : g_fwd_seam
            assign fwd_src = split_nx ? dual_in : stage_q[i-1];
        end else begin : g_fwd_body
            assign fwd_src = stage_q[i-1];
        end

        if (i == STAGES - 1) begin : g_rev_head
            assign rev_src = head_in;
        end else if (i == HALF - 1) begin : g_rev_seam
            assign rev_src = split_nx ? dual_in : stage_q[i+1];
        end else begin : g_rev_body
            assign rev_src = stage_q[i+1];
        end

        assign stage_nx[i] = rev_nx ? rev_src : fwd_src;
    end

    // Stage storage: clear on reset, advance on a latch pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= stage_nx;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q)); // R2
    AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !rev_nx) |=> (stage_q[0] == $past(head_in))); // R3
    AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && rev_nx) |=> (stage_q[STAGES-1] == $past(head_in))); // R4
    AST_DUAL_SEAM: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && split_nx && !rev_nx) |=> (stage_q[HALF] == $past(dual_in))); // R5

endmodule

// File: rtl/rowscan_cfg.sv
// Topology capture, edge pin roles and serial-out selection.
// Assumes: the topology is loaded only on a shift. Between shifts
// it stays fixed, so pin roles follow the last shift.
module rowscan_cfg
    import rowscan_pkg::*;
#(
    parameter int STAGES = 240,
    localparam int HALF = STAGES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              split_pin,
    input  logic              rev_pin,
    input  logic [STAGES-1:0] stage_q,
    output logic              a_out,
    output logic              a_oe,
    output logic              b_out,
    output logic              b_oe
);

    topo_t topo_q;
    logic  sout;

    // Topology register: loaded together with the stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            topo_q <= TOPO_RESET;
        end else if (shift_en) begin
            topo_q <= '{split: split_pin, rev: rev_pin};
        end
    end

    // Serial out: last stage of the pin-fed chain
    always_comb begin
        case ({topo_q.split, topo_q.rev})
            2'b00:   sout = stage_q[STAGES-1];
            2'b01:   sout = stage_q[0];
            2'b10:   sout = stage_q[HALF-1];
            default: sout = stage_q[HALF];
        endcase
    end

    // Pin roles: the far edge from the input side drives
    always_comb begin
        a_oe  = topo_q.rev;
        b_oe  = !topo_q.rev;
        a_out = topo_q.rev ? sout : 1'b0;
        b_out = topo_q.rev ? 1'b0 : sout;
    end

    AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({a_oe, b_oe}) == 1); // R7
    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> ($stable(a_oe) && $stable(b_oe))); // R8

endmodule

// File: rtl/rowscan_out.sv
// Combines the stage vector with frame polarity and display blank.
// Assumes: this path is combinational; the level stages register it.
module rowscan_out #(
    parameter int STAGES = 240
) (
    input  logic              fr,
    input  logic              disp_off,
    input  logic [STAGES-1:0] stage_q,
    output logic [STAGES-1:0] row_sel,
    output logic [STAGES-1:0] row_hi
);

    // Per-row select flag and level phase
    for (genvar i = 0; i < STAGES; i++) begin : g_row
        assign row_sel[i] = stage_q[i] & !disp_off;
        assign row_hi[i]  = !disp_off & (stage_q[i] ? fr : !fr);
    end

    // Blank check: no row may be active while the display is off
    always_comb begin
        if (disp_off === 1'b1) begin
            AST_BLANK_ALL: assert ((row_sel | row_hi) == '0); // R10
        end
    end

endmodule

// File: rtl/rowscan_shifter.sv
// Top of the row scan register: stage chain, topology and edge pins,
// and the output combiner.
// Assumes: shift_en is a one-cycle strobe synchronous to clk.
module rowscan_shifter #(
    parameter int STAGES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              split_sel,
    input  logic              dir_rev,
    input  logic              fr,
    input  logic              disp_off,
    input  logic              a_in,
    output logic              a_out,
    output logic              a_oe,
    input  logic              b_in,
    output logic              b_out,
    output logic              b_oe,
    input  logic              dual_in,
    output logic [STAGES-1:0] row_sel,
    output logic [STAGES-1:0] row_hi
);

    logic [STAGES-1:0] stage_q;
    logic              head_in;

    // Chain input: the edge pin on the side the data enters from
    assign head_in = dir_rev ? b_in : a_in;

    rowscan_chain #(.STAGES(STAGES)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .split_nx (split_sel),
        .rev_nx   (dir_rev),
        .head_in  (head_in),
        .dual_in  (dual_in),
        .stage_q  (stage_q)
    );

    rowscan_cfg #(.STAGES(STAGES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .split_pin (split_sel),
        .rev_pin   (dir_rev),
        .stage_q   (stage_q),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    rowscan_out #(.STAGES(STAGES)) u_out (
        .fr       (fr),
        .disp_off (disp_off),
        .stage_q  (stage_q),
        .row_sel  (row_sel),
        .row_hi   (row_hi)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (stage_q == '0 && b_oe && !a_oe)); // R1

endmodule

// File: tb/rowscan_shifter_bench.sv
module rowscan_shifter_bench;

    localparam int S = 240;
    localparam int H = S / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_en = 1'b0, split_sel = 1'b0, dir_rev = 1'b0;
    logic         fr = 1'b0, disp_off = 1'b0;
    logic         a_in = 1'b0, b_in = 1'b0, dual_in = 1'b0;
    logic         a_out, a_oe, b_out, b_oe;
    logic [S-1:0] row_sel, row_hi;

    int checks = 0;
    int errors = 0;

    logic [S-1:0] m_q = '0;
    logic         m_split = 1'b0, m_rev = 1'b0;

    rowscan_shifter #(.STAGES(S)) u_rowscan_shifter (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .split_sel(split_sel),
        .dir_rev(dir_rev), .fr(fr), .disp_off(disp_off),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .dual_in(dual_in), .row_sel(row_sel), .row_hi(row_hi)
    );

    always #10 clk = ~clk;

    // Expected next rows from the topology rules (R3..R6)
    function automatic logic [S-1:0] next_rows(logic [S-1:0] q, logic sp, logic rv,
                                               logic ai, logic bi, logic di);
        logic [S-1:0] n;
        if (!rv) begin
            n = {q[S-2:0], ai};
            if (sp) n[H] = di;
        end else begin
            n = {bi, q[S-1:1]};
            if (sp) n[H-1] = di;
        end
        return n;
    endfunction

    function automatic logic exp_sout(logic [S-1:0] q, logic sp, logic rv);
        if (sp) return rv ? q[H] : q[H-1];
        return rv ? q[0] : q[S-1];
    endfunction

    function automatic string topo_tag(logic sp, logic rv);
        if (sp) return rv ? "R6" : "R5";
        return rv ? "R4" : "R3";
    endfunction

    task automatic chk(bit ok, string tag, logic [S-1:0] act, logic [S-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic step();
        string tag;
        logic  s, ea, eb;
        @(posedge clk);
        tag = shift_en ? topo_tag(split_sel, dir_rev) : "R2";
        if (!rst_n) begin
            m_q = '0; m_split = 1'b0; m_rev = 1'b0; tag = "R1";
        end else if (shift_en) begin
            m_q = next_rows(m_q, split_sel, dir_rev, a_in, b_in, dual_in);
            m_split = split_sel; m_rev = dir_rev;
        end
        @(negedge clk);
        if (disp_off) begin
            chk((row_sel | row_hi) == '0, "R10", row_sel | row_hi, '0);
        end else begin
            chk(row_sel == m_q, tag, row_sel, m_q);
            chk(row_hi == (fr ? m_q : ~m_q), "R9", row_hi, fr ? m_q : ~m_q);
        end
        s  = exp_sout(m_q, m_split, m_rev);
        ea = m_rev ? s : 1'b0;
        eb = m_rev ? 1'b0 : s;
        chk({a_oe, b_oe} == {m_rev, !m_rev}, "R7", S'({a_oe, b_oe}), S'({m_rev, !m_rev}));
        chk({a_out, b_out} == {ea, eb}, (tag == "R2") ? "R8" : tag,
            S'({a_out, b_out}), S'({ea, eb}));
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        step(); step();
        // R1: reset state
        chk(row_sel == '0 && b_oe && !a_oe, "R1", row_sel, '0);
        rst_n = 1'b1;

        // R3: token walk through the single forward chain to b_out
        a_in = 1'b1; shift_en = 1'b1; step();
        a_in = 1'b0;
        for (int i = 1; i < S; i++) step();
        chk(b_out == 1'b1, "R3", S'(b_out), S'(1));

        // R5: dual forward seam, token at row 120 leaves, row 121 takes dual_in
        split_sel = 1'b1; dual_in = 1'b0; shift_en = 1'b0;
        rst_n = 1'b0; step(); rst_n = 1'b1;
        a_in = 1'b1; shift_en = 1'b1; step(); a_in = 1'b0;
        for (int i = 1; i < H; i++) step();
        chk(b_out == 1'b1 && row_sel[H-1], "R5", S'(b_out), S'(1));
        step();
        chk(row_sel[H] == 1'b0, "R5", S'(row_sel[H]), S'(0));

        // R8: topology pins change with no shift: no output change
        shift_en = 1'b0; dir_rev = 1'b1; step(); step();
        chk(a_oe == 1'b0 && b_oe == 1'b1, "R8", S'({a_oe, b_oe}), S'(2'b01));
        shift_en = 1'b1; b_in = 1'b1; step();
        chk(a_oe == 1'b1 && row_sel[S-1], "R8", S'({a_oe, row_sel[S-1]}), S'(2'b11));

        // R10: blank with rows selected
        disp_off = 1'b1; shift_en = 1'b0; step();
        disp_off = 1'b0;

        // Random mix of topologies, shifts, polarity and blanking
        for (int i = 0; i < 4000; i++) begin
            shift_en = ($urandom % 2) == 0;
            a_in     = ($urandom % 5) == 0;
            b_in     = ($urandom % 5) == 0;
            dual_in  = ($urandom % 5) == 0;
            fr       = $urandom % 2;
            disp_off = ($urandom % 8) == 0;
            if (($urandom % 40) == 0) split_sel = $urandom % 2;
            if (($urandom % 40) == 0) dir_rev = $urandom % 2;
            rst_n    = ($urandom % 500) != 0;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule